// File: doc/BRIEF.md
# Audio Subframe Formatter with Channel-Status Insertion

The block takes interleaved 24-bit PCM samples for a stream of 2 to 8 channels and turns each one into a 32-bit IEC-958-style subframe word for a downstream transmitter. For every sample it sets a channel-status bit, a block-start flag and an even-parity bit. The audio payload sits in the low 24 bits, and the other unused bit positions are driven to zero. The user-data and validity bits are also zero.

Software provides four channel-status bytes. The block spreads them one bit per frame across a 192-frame block, least significant bit first. In each channel's copy, one nibble of the third byte is replaced by that channel's number. A frame counter and a channel index follow the interleave. A synchronous clear input sets both back to the start of a block.

Both the input and the output are valid/ready streams. One output register sits between them. When the output is stalled, the input is held back: no sample is lost and neither counter moves.

Top module: `iecf_formatter`

## Requirements
- R1: Output bits 23..0 equal bits 23..0 of the accepted input sample. Input bits 31..24 have no effect on the output.
- R2: Output bits 31..29 and 25..24 are always zero.
- R3: Output bit 26 is the channel-status bit for the current frame f (0..191). For f < 32 it is bit (f mod 8) of status byte f/8. Status byte k occupies bits 8k+7..8k of `status_i`. For f >= 32 it is zero.
- R4: For frames 20..23 (bits 7..4 of status byte 2), output bit 26 is instead bit (f-20) of the 4-bit value (channel index + 1). Channel indices count from 0.
- R5: Output bit 28 is 1 only on the word for frame 0, channel 0. It is 0 on every other word.
- R6: Output bit 27 equals the XOR of output bits 26..0, so bits 27..0 together have even parity.
- R7: Samples are taken as channel 0, 1, …, N-1 of one frame, where N is `chan_cnt_i` (2..8). The frame index advances after channel N-1 and wraps from 191 to 0.
- R8: While `clr_i` is high, `in_ready_o` is low and the output register is emptied. The first sample accepted afterwards is frame 0, channel 0.
- R9: While `out_valid_o` is high and `out_ready_i` is low, the output word is held unchanged. No sample is dropped and the counters do not advance.
- R10: After reset, `out_valid_o` is low, `in_ready_o` is high, and the first sample is frame 0, channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Synchronous restart of the frame and channel counters |
| chan_cnt_i | input | 4 | Channels per frame, 2..8 |
| status_i | input | 32 | Four channel-status bytes, byte k in bits 8k+7..8k |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Input sample accepted when high with valid |
| in_sample_i | input | 32 | Sample; only bits 23..0 are used |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream ready |
| out_word_o | output | 32 | Formatted subframe word |

## Verification
The bench builds the block with its default parameters: 24-bit samples, up to 8 channels, a 192-frame block and 4 status bytes. With these values it can run streams of 2, 8 and 3 channels. The 2-channel and 8-channel runs go past frame 191, so the block-start flag is seen again after the wrap. Irregular output backpressure during the multichannel runs exercises the stall path. The clear input is pulsed between the runs and the channel count is changed there.

// File: rtl/iecf_pkg.sv
package iecf_pkg;

  localparam int WORD_W = 32;
  localparam int BIT_CS = 26;
  localparam int BIT_PAR = 27;
  localparam int BIT_BLK = 28;

  function automatic logic even_par(input logic [WORD_W-1:0] w);
    return ^w[BIT_CS:0];
  endfunction

endpackage

// File: rtl/iecf_sequencer.sv
module iecf_sequencer #(
  parameter int MAX_CH    = 8,
  parameter int BLOCK_LEN = 192,
  parameter int CNT_W     = 4,
  localparam int CH_W     = $clog2(MAX_CH),
  localparam int FR_W     = $clog2(BLOCK_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  input  logic [CNT_W-1:0] chan_cnt,
  output logic [CH_W-1:0]  ch,
  output logic [FR_W-1:0]  frame
);

  logic [CNT_W-1:0] ch_ext;
  logic             last_ch;

  assign ch_ext  = CNT_W'(ch);
  assign last_ch = (ch_ext >= chan_cnt - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ch    <= '0;
      frame <= '0;
    end else if (step) begin
      if (last_ch) begin
        ch <= '0;
        if (frame == FR_W'(BLOCK_LEN - 1)) frame <= '0;
        else                               frame <= frame + FR_W'(1);
      end else begin
        ch <= ch + CH_W'(1);
      end
    end
  end

endmodule

// File: rtl/iecf_status_bit.sv
module iecf_status_bit #(
  parameter int MAX_CH       = 8,
  parameter int BLOCK_LEN    = 192,
  parameter int STATUS_BYTES = 4,
  parameter int CHNUM_BYTE   = 2,
  localparam int CH_W        = $clog2(MAX_CH),
  localparam int FR_W        = $clog2(BLOCK_LEN),
  localparam int ST_FRAMES   = 8 * STATUS_BYTES,
  localparam int ST_W        = $clog2(ST_FRAMES),
  localparam int CHF_LO      = 8 * CHNUM_BYTE + 4,
  localparam int CHF_HI      = CHF_LO + 3
) (
  input  logic [FR_W-1:0]      frame,
  input  logic [CH_W-1:0]      ch,
  input  logic [ST_FRAMES-1:0] status,
  output logic                 cs_bit
);

  logic [3:0] chnum;
  logic [1:0] chsel;

  assign chnum = 4'(ch) + 4'd1;
  assign chsel = 2'(frame - FR_W'(CHF_LO));

  always_comb begin
    cs_bit = 1'b0;
    if (frame < FR_W'(ST_FRAMES)) begin
      if (frame >= FR_W'(CHF_LO) && frame <= FR_W'(CHF_HI))
        cs_bit = chnum[chsel];
      else
        cs_bit = status[frame[ST_W-1:0]];
    end
  end

endmodule

// File: rtl/iecf_assemble.sv
module iecf_assemble
  import iecf_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic [SAMPLE_W-1:0] sample,
  input  logic                cs_bit,
  input  logic                blk_start,
  output logic [WORD_W-1:0]   word
);

  logic [WORD_W-1:0] base;

  always_comb begin
    base                 = '0;
    base[SAMPLE_W-1:0]   = sample;
    base[BIT_CS]         = cs_bit;
    word                 = base;
    word[BIT_PAR]        = even_par(base);
    word[BIT_BLK]        = blk_start;
  end

endmodule

// File: rtl/iecf_formatter.sv
module iecf_formatter
  import iecf_pkg::*;
#(
  parameter int SAMPLE_W     = 24,
  parameter int MAX_CH       = 8,
  parameter int BLOCK_LEN    = 192,
  parameter int STATUS_BYTES = 4,
  localparam int CNT_W       = $clog2(MAX_CH + 1),
  localparam int CH_W        = $clog2(MAX_CH),
  localparam int FR_W        = $clog2(BLOCK_LEN),
  localparam int ST_W        = 8 * STATUS_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic [CNT_W-1:0]  chan_cnt_i,
  input  logic [ST_W-1:0]   status_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_sample_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_word_o
);

  logic [CH_W-1:0]   ch;
  logic [FR_W-1:0]   frame;
  logic              cs_bit;
  logic              take;
  logic [WORD_W-1:0] word_nx;

  assign in_ready_o = (!out_valid_o || out_ready_i) && !clr_i;
  assign take       = in_valid_i && in_ready_o;

  iecf_sequencer #(
    .MAX_CH(MAX_CH), .BLOCK_LEN(BLOCK_LEN), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst(rst), .clr(clr_i), .step(take),
    .chan_cnt(chan_cnt_i), .ch(ch), .frame(frame)
  );

  iecf_status_bit #(
    .MAX_CH(MAX_CH), .BLOCK_LEN(BLOCK_LEN), .STATUS_BYTES(STATUS_BYTES)
  ) u_cs (
    .frame(frame), .ch(ch), .status(status_i), .cs_bit(cs_bit)
  );

  iecf_assemble #(
    .SAMPLE_W(SAMPLE_W)
  ) u_asm (
    .sample(in_sample_i[SAMPLE_W-1:0]), .cs_bit(cs_bit),
    .blk_start(frame == '0 && ch == '0), .word(word_nx)
  );

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      out_valid_o <= 1'b0;
      out_word_o  <= '0;
    end else if (take) begin
      out_valid_o <= 1'b1;
      out_word_o  <= word_nx;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

endmodule

// File: rtl/iecf_formatter_chk.sv
module iecf_formatter_chk (
  input logic        clk,
  input logic        rst,
  input logic        clr_i,
  input logic        in_ready_o,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [31:0] out_word_o
);

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
    out_valid_o && !out_ready_i && !clr_i |=> out_valid_o && $stable(out_word_o)); // R9
  AST_ZERO_FIELDS: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> (out_word_o[31:29] == 3'b000) && (out_word_o[25:24] == 2'b00)); // R2
  AST_EVEN_PARITY: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> (^out_word_o[27:0]) == 1'b0); // R6
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !out_valid_o); // R8
  AST_CLR_BLOCKS_IN: assert property (@(posedge clk) disable iff (rst)
    clr_i |-> !in_ready_o); // R8
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> !out_valid_o); // R10

endmodule

bind iecf_formatter iecf_formatter_chk u_chk (
  .clk(clk), .rst(rst), .clr_i(clr_i), .in_ready_o(in_ready_o),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_word_o(out_word_o)
);

// File: tb/iecf_formatter_tb.sv
module iecf_formatter_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr = 1'b0;
  logic [3:0]  chan_cnt = 4'd2;
  logic [31:0] status = 32'h0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_sample = 32'h0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_word;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];
  int          frm_q[$];
  bit          bp_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  int          m_fr = 0;
  int          m_ch = 0;

  always #2 clk = ~clk;

  iecf_formatter u_dut (
    .clk(clk), .rst(rst), .clr_i(clr), .chan_cnt_i(chan_cnt), .status_i(status),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_sample_i(in_sample),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_word_o(out_word)
  );

  function automatic logic [31:0] exp_word(logic [31:0] s, int fr, int ch, logic [31:0] st);
    logic cs;
    logic [3:0] cn;
    logic [31:0] w;
    cs = 1'b0;
    cn = 4'(ch + 1);
    if (fr < 32) begin
      if (fr >= 20 && fr <= 23) cs = cn[fr-20];
      else cs = st[fr];
    end
    w = {3'b000, (fr == 0 && ch == 0), 1'b0, cs, 2'b00, s[23:0]};
    w[27] = ^w[26:0];
    return w;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic send(logic [31:0] s);
    @(negedge clk);
    in_valid = 1'b1;
    in_sample = s;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(exp_word(s, m_fr, m_ch, status));
    frm_q.push_back(m_fr);
    m_ch++;
    if (m_ch >= int'(chan_cnt)) begin
      m_ch = 0;
      m_fr = (m_fr == 191) ? 0 : m_fr + 1;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || out_valid) @(negedge clk);
  endtask

  task automatic restart(logic [3:0] n, logic [31:0] st);
    @(negedge clk);
    clr = 1'b1;
    chan_cnt = n;
    status = st;
    @(negedge clk);
    check(!out_valid, "R8 valid after clear", {31'b0, out_valid}, 32'h0);
    clr = 1'b0;
    m_fr = 0;
    m_ch = 0;
  endtask

  // scoreboard monitor
  logic        prev_hold = 1'b0;
  logic [31:0] prev_word = 32'h0;
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (prev_hold && !clr)
          check(out_valid && out_word == prev_word, "R9 stalled word", out_word, prev_word);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = bp_en ? (lfsr[0] | lfsr[3]) : 1'b1;
        prev_hold = out_valid && !out_ready;
        prev_word = out_word;
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R9 unexpected word", out_word, 32'h0);
          end else begin
            logic [31:0] e;
            int f;
            e = exp_q.pop_front();
            f = frm_q.pop_front();
            check(out_word[23:0] == e[23:0], "R1 sample field", out_word, e);
            check(out_word[31:29] == 3'b0 && out_word[25:24] == 2'b0, "R2 zero fields", out_word, e);
            if (f >= 20 && f <= 23)
              check(out_word[26] == e[26], "R4 channel number bit", out_word, e);
            else
              check(out_word[26] == e[26], "R3 status bit", out_word, e);
            check(out_word[28] == e[28], "R5 R7 block start", out_word, e);
            check(out_word[27] == e[27], "R6 parity", out_word, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    status = 32'hA53C_F081;
    chan_cnt = 4'd2;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(!out_valid, "R10 valid after reset", {31'b0, out_valid}, 32'h0);
    check(in_ready, "R10 ready after reset", {31'b0, in_ready}, 32'h1);

    // two channels, past the block wrap, upper input bits set
    for (int i = 0; i < 2 * 200; i++)
      send({8'hFF ^ 8'(i), 24'(i * 32'h9E3779)});
    drain();

    // eight channels with backpressure
    restart(4'd8, 32'h5F00_C3E7);
    bp_en = 1'b1;
    for (int i = 0; i < 8 * 195; i++)
      send({8'(i), 24'(i * 32'h1234567 + 5)});
    drain();

    // three channels, fresh block after clear
    restart(4'd3, 32'hFFFF_FFFF);
    for (int i = 0; i < 3 * 40; i++)
      send(32'hC0_00_00_00 | 32'(i * 77));
    drain();
    bp_en = 1'b0;

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule